// File: doc/BRIEF.md
# Processor Boot Handshake Controller

This block arbitrates a single SRAM between a host port and a soft processor that sits in a boot wait loop. After reset the host owns the SRAM address, write data, write strobe and output enable. The host waits for a ready pulse, loads a program, then presents a start request together with a nonzero program entry address. The controller hands the SRAM to the processor and answers the processor's reads of a fixed pointer location with that entry address. The boot loop can then leave its polling and jump into the program.

Readiness is found by watching the processor address bus. An instruction fetch of the boot code's check-loop address tells the controller that the processor is parked. The first such fetch after reset raises the ready indication. During a run, the same fetch is counted only after the processor has fetched some other address. This keeps the polling that goes on just after start from ending the run at once. When the run ends, the SRAM returns to the host so it can read the results, and another start may follow.

All SRAM-side outputs are registered, so every command reaches the SRAM one clock after it is presented. Return data passes through to whichever side owns the bus. While the host owns the bus, the processor read-data drive enable is held low so that its pad can float.

Top module: `boot_handoff_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, cpu_go, host_ready, cpu_rdata_oe, sram_we and sram_oe are all 0.
- R2: After reset, a fetch of CHECK_ADDR (cpu_fetch=1) presented in cycle t makes host_ready 1 after clock edge t+2. Ownership stays with the host.
- R3: A presentation of CHECK_ADDR counts only when cpu_fetch is 1. A data read of that address (cpu_rd=1, cpu_fetch=0) changes neither host_ready nor cpu_go.
- R4: While cpu_go is 0, sram_addr, sram_wdata and sram_we equal the host inputs one edge later. sram_oe equals host_rd and not host_wr. Processor writes do not reach the SRAM.
- R5: While the host owns the bus, cpu_rdata_oe is 0 and cpu_rdata reads 0. host_rdata carries sram_rdata.
- R6: In a ready state, host_start with a nonzero host_entry sets cpu_go to 1 after the next edge. From the edge after that, the SRAM bus follows the processor inputs, with sram_oe = (cpu_rd or cpu_fetch) and not cpu_wr.
- R7: host_start has no effect before the first ready indication, while a run is in progress, or when host_entry is 0.
- R8: While the processor owns the bus, a read of PTR_ADDR returns the entry address captured at the accepted start, not the SRAM content.
- R9: In a run, fetches of CHECK_ADDR do not end the run until a fetch of another address has been seen. The next CHECK_ADDR fetch then clears cpu_go two edges later.
- R10: host_ready is a single-cycle pulse, raised once on each entry to a ready state. Further check-loop fetches in that state raise no further pulse.
- R11: After a run has ended, a new start with a new entry address begins a new run, and pointer reads return the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_fetch | input | 1 | Processor instruction-fetch cycle valid |
| cpu_rd | input | 1 | Processor data read |
| cpu_wr | input | 1 | Processor write |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data to the processor |
| cpu_rdata_oe | output | 1 | Drive enable for the processor data pad |
| host_addr | input | ADDR_W | Host word address |
| host_rd | input | 1 | Host read |
| host_wr | input | 1 | Host write |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data to the host |
| host_start | input | 1 | Start request |
| host_entry | input | DATA_W | Program entry address offered with start |
| host_ready | output | 1 | Ready pulse to the host |
| cpu_go | output | 1 | Processor owns the SRAM |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_we | output | 1 | SRAM write strobe |
| sram_oe | output | 1 | SRAM output enable |
| sram_rdata | input | DATA_W | SRAM read data |

## Verification
The detector is driven with the check-loop address under three patterns, and each pattern separates a different fault. A data read of that address shows whether the fetch qualifier is honoured. Repeated fetches just after start show whether the arming step exists. A fetch of another address followed by a check-loop fetch must end the run with a single pulse. Bus ownership is tried by host writes and reads, processor writes while the host owns the bus, and pointer reads before and after a restart. These show whether the mux select, the data release and the entry override each follow the right state. Start requests given in the boot state, during a run and with a zero entry must each leave cpu_go low or unchanged.

// File: rtl/boot_handoff_pkg.sv
package boot_handoff_pkg;

  typedef enum logic [1:0] {
    ST_BOOT       = 2'd0,
    ST_READY_IDLE = 2'd1,
    ST_RUNNING    = 2'd2,
    ST_DONE_READY = 2'd3
  } bh_state_e;

  function automatic logic is_ready_state(input bh_state_e s);
    return (s == ST_READY_IDLE) || (s == ST_DONE_READY);
  endfunction

endpackage

// File: rtl/bh_fetch_snoop.sv
module bh_fetch_snoop #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CHECK_ADDR = 12'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  output logic              hit_q,
  output logic              other_q
);

  logic addr_eq;
  assign addr_eq = (cpu_addr == CHECK_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      other_q <= 1'b0;
    end else begin
      hit_q   <= cpu_fetch && addr_eq;
      other_q <= cpu_fetch && !addr_eq;
    end
  end

  // R3: a counted hit always comes from a fetch cycle
  a_r3_hit_needs_fetch: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(cpu_fetch));

  a_r9_hit_other_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hit_q && other_q));

endmodule

// File: rtl/bh_fsm.sv
module bh_fsm
  import boot_handoff_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_q,
  input  logic              other_q,
  input  logic              host_start,
  input  logic [DATA_W-1:0] host_entry,
  output logic              go,
  output logic              ready_pulse,
  output logic [DATA_W-1:0] entry_q
);

  bh_state_e state, nxt;
  logic      armed;
  logic      start_ok;
  logic      run_end;

  assign start_ok = is_ready_state(state) && host_start && (host_entry != '0);
  assign run_end  = (state == ST_RUNNING) && armed && hit_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT:       if (hit_q)    nxt = ST_READY_IDLE;
      ST_READY_IDLE: if (start_ok) nxt = ST_RUNNING;
      ST_RUNNING:    if (run_end)  nxt = ST_DONE_READY;
      ST_DONE_READY: if (start_ok) nxt = ST_RUNNING;
      default:                     nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_BOOT;
      go          <= 1'b0;
      ready_pulse <= 1'b0;
      armed       <= 1'b0;
      entry_q     <= '0;
    end else begin
      state       <= nxt;
      go          <= (nxt == ST_RUNNING);
      ready_pulse <= is_ready_state(nxt) && !is_ready_state(state);
      armed       <= (state == ST_RUNNING && nxt == ST_RUNNING) ? (armed | other_q) : 1'b0;
      if (start_ok) entry_q <= host_entry;
    end
  end

  a_r10_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready_pulse |=> !ready_pulse);

  a_r6_start_sets_go: assert property (@(posedge clk) disable iff (rst)
    (is_ready_state(state) && host_start && host_entry != '0) |=> go);

  a_r7_run_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNNING && !(armed && hit_q)) |=> (state == ST_RUNNING));

  a_r7_boot_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BOOT && !hit_q) |=> (state == ST_BOOT && !go));

  a_r9_end_releases: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNNING && armed && hit_q) |=> (!go && ready_pulse));

  a_r7_entry_stable: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUNNING) |=> $stable(entry_q));

endmodule

// File: rtl/bh_bus_mux.sv
module bh_bus_mux #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PTR_ADDR = 12'h0F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] entry_q,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  output logic              sram_oe,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [DATA_W-1:0] host_rdata
);

  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sel_we, sel_oe, sel_ptr;
  logic              own_q, ptr_q;

  always_comb begin
    if (go) begin
      sel_addr  = cpu_addr;
      sel_wdata = cpu_wdata;
      sel_we    = cpu_wr;
      sel_oe    = (cpu_rd || cpu_fetch) && !cpu_wr;
      sel_ptr   = cpu_rd && !cpu_wr && (cpu_addr == PTR_ADDR);
    end else begin
      sel_addr  = host_addr;
      sel_wdata = host_wdata;
      sel_we    = host_wr;
      sel_oe    = host_rd && !host_wr;
      sel_ptr   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_we    <= 1'b0;
      sram_oe    <= 1'b0;
      own_q      <= 1'b0;
      ptr_q      <= 1'b0;
    end else begin
      sram_addr  <= sel_addr;
      sram_wdata <= sel_wdata;
      sram_we    <= sel_we;
      sram_oe    <= sel_oe;
      own_q      <= go;
      ptr_q      <= sel_ptr;
    end
  end

  assign cpu_rdata_oe = own_q;
  assign cpu_rdata    = own_q ? (ptr_q ? entry_q : sram_rdata) : '0;
  assign host_rdata   = own_q ? '0 : sram_rdata;

  a_r4_host_addr: assert property (@(posedge clk) disable iff (rst)
    !go |=> (sram_addr == $past(host_addr) && sram_we == $past(host_wr)));

  a_r4_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
    !(sram_we && sram_oe));

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    !go |=> !cpu_rdata_oe);

  a_r6_cpu_addr: assert property (@(posedge clk) disable iff (rst)
    go |=> (sram_addr == $past(cpu_addr) && sram_we == $past(cpu_wr)));

endmodule

// File: rtl/boot_handoff_ctrl.sv
module boot_handoff_ctrl
  import boot_handoff_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CHECK_ADDR = 12'h040,
  parameter logic [ADDR_W-1:0] PTR_ADDR   = 12'h0F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_fetch,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              host_start,
  input  logic [DATA_W-1:0] host_entry,
  output logic              host_ready,
  output logic              cpu_go,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              sram_we,
  output logic              sram_oe,
  input  logic [DATA_W-1:0] sram_rdata
);

  logic              hit_q, other_q;
  logic [DATA_W-1:0] entry_q;

  bh_fetch_snoop #(.ADDR_W(ADDR_W), .CHECK_ADDR(CHECK_ADDR)) u_snoop (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch),
    .hit_q(hit_q), .other_q(other_q)
  );

  bh_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .hit_q(hit_q), .other_q(other_q),
    .host_start(host_start), .host_entry(host_entry),
    .go(cpu_go), .ready_pulse(host_ready), .entry_q(entry_q)
  );

  bh_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_ADDR(PTR_ADDR)) u_mux (
    .clk(clk), .rst(rst), .go(cpu_go),
    .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .entry_q(entry_q), .sram_rdata(sram_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .sram_oe(sram_oe), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .host_rdata(host_rdata)
  );

endmodule

// File: tb/boot_handoff_ctrl_tb.sv
module boot_handoff_ctrl_tb;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] CHK = 12'h040;
  localparam logic [AW-1:0] PTR = 12'h0F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_fetch = 0, cpu_rd = 0, cpu_wr = 0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_rdata_oe;
  logic [AW-1:0] host_addr = '0;
  logic host_rd = 0, host_wr = 0, host_start = 0;
  logic [DW-1:0] host_wdata = '0, host_entry = '0;
  logic [DW-1:0] host_rdata;
  logic host_ready, cpu_go;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic sram_we, sram_oe;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #2.5 clk = ~clk;

  always @(posedge clk) if (sram_we) mem[sram_addr] <= sram_wdata;
  assign sram_rdata = sram_oe ? mem[sram_addr] : '0;

  boot_handoff_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CHECK_ADDR(CHK), .PTR_ADDR(PTR)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_start(host_start),
    .host_entry(host_entry), .host_ready(host_ready), .cpu_go(cpu_go),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .sram_oe(sram_oe), .sram_rdata(sram_rdata)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_idle();
    cpu_fetch = 0; cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic test_reset();
    chk("R1 go", cpu_go, 0);
    chk("R1 ready", host_ready, 0);
    chk("R1 oe", cpu_rdata_oe, 0);
    chk("R1 we", sram_we, 0);
    chk("R1 sram_oe", sram_oe, 0);
  endtask

  task automatic test_boot();
    host_start = 1; host_entry = 32'h100;
    tick(); host_start = 0; tick();
    chk("R7 start in boot", cpu_go, 0);
    cpu_addr = CHK; cpu_rd = 1;
    repeat (4) begin
      tick();
      chk("R3 data read no ready", host_ready, 0);
    end
    cpu_rd = 0; cpu_fetch = 1;
    tick();
    chk("R2 not yet", host_ready, 0);
    tick();
    chk("R2 ready pulse", host_ready, 1);
    chk("R2 host still owns", cpu_go, 0);
    tick();
    chk("R10 pulse one cycle", host_ready, 0);
    repeat (3) begin
      tick();
      chk("R10 no repeat pulse", host_ready, 0);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    tick();
    host_wr = 0;
    chk("R4 we", sram_we, 1);
    chk("R4 addr", sram_addr, a);
    chk("R4 wdata", sram_wdata, d);
  endtask

  task automatic host_read(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    host_addr = a; host_rd = 1;
    tick();
    host_rd = 0;
    chk(req, host_rdata, exp);
  endtask

  task automatic test_host_load();
    host_write(12'h200, 32'hA5A5_0001);
    host_write(12'h201, 32'hA5A5_0002);
    cpu_idle(); cpu_addr = 12'h201; cpu_wr = 1; cpu_wdata = 32'hDEAD;
    host_addr = 12'h200; host_rd = 1;
    tick();
    cpu_wr = 0; host_rd = 0;
    chk("R4 oe follows host", sram_oe, 1);
    chk("R4 host read", host_rdata, 32'hA5A5_0001);
    chk("R5 cpu oe low", cpu_rdata_oe, 0);
    chk("R5 cpu rdata zero", cpu_rdata, 0);
    host_read("R4 cpu write blocked", 12'h201, 32'hA5A5_0002);
  endtask

  task automatic test_start();
    host_start = 1; host_entry = '0;
    tick(); host_start = 0; tick();
    chk("R7 zero entry", cpu_go, 0);
    cpu_addr = CHK; cpu_fetch = 1;
    host_start = 1; host_entry = 32'h0000_0200;
    tick(); host_start = 0;
    chk("R6 go", cpu_go, 1);
    repeat (4) begin
      tick();
      chk("R9 not armed", cpu_go, 1);
    end
    cpu_fetch = 0; cpu_rd = 1; cpu_addr = PTR;
    tick();
    chk("R8 pointer", cpu_rdata, 32'h200);
    chk("R6 cpu oe", cpu_rdata_oe, 1);
    host_start = 1; host_entry = 32'h300;
    tick(); host_start = 0;
    tick();
    chk("R7 start while running", cpu_rdata, 32'h200);
    cpu_rd = 0; cpu_fetch = 1; cpu_addr = 12'h200;
    tick();
    chk("R6 cpu fetch data", cpu_rdata, 32'hA5A5_0001);
    chk("R6 sram oe", sram_oe, 1);
  endtask

  task automatic test_finish();
    cpu_fetch = 0; cpu_addr = 12'h300; cpu_wr = 1; cpu_wdata = 32'h1234_5678;
    tick();
    chk("R6 cpu write", sram_we, 1);
    chk("R6 cpu addr", sram_addr, 12'h300);
    cpu_wr = 0; cpu_fetch = 1; cpu_addr = 12'h201;
    tick();
    cpu_addr = CHK;
    tick();
    chk("R9 run still on", cpu_go, 1);
    tick();
    chk("R9 go dropped", cpu_go, 0);
    chk("R10 ready on done", host_ready, 1);
    tick();
    chk("R10 done pulse one cycle", host_ready, 0);
    host_read("R4 result readback", 12'h300, 32'h1234_5678);
  endtask

  task automatic test_restart();
    host_start = 1; host_entry = 32'h0000_0777;
    tick(); host_start = 0;
    chk("R11 go again", cpu_go, 1);
    cpu_fetch = 0; cpu_rd = 1; cpu_addr = PTR;
    tick();
    chk("R11 new pointer", cpu_rdata, 32'h777);
    cpu_idle();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    #1;
    test_reset();
    repeat (3) tick();
    rst = 0;
    tick();
    test_reset();
    test_boot();
    cpu_idle();
    test_host_load();
    test_start();
    test_finish();
    test_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule